// File: doc/BRIEF.md
# DMA Cache-Injection Hint Forwarder

This block lives inside the memory controller, between a bus-mastering I/O device and the processor bus. Each write beat the device presents goes straight to the memory port, whether or not the transfer asks for cache injection. A transfer can carry an injection hint. When it does, the beats that make up the start of the transfer (the packet header, the first `HDR_BYTES` bytes) are also copied onto the processor bus with an injection marker. The copy goes out in the same cycle that memory accepts the beat.

A small processor-side snoop stub watches the bus all the time. When it sees a marked beat and its install policy allows it, it places the beat in a one-entry fill register that stands for the lowest-level cache's fill port. The marker is only a hint. If the bus is busy or the stub cannot accept the beat, the copy is dropped and the memory write goes ahead without delay.

Once the final beat of a transfer has been accepted by memory, a completion interrupt goes high in the next cycle. It stays high until the processor acknowledges it.

Top module: `dma_inject_fwd`

## Requirements
- R1: Every device beat reaches memory unchanged: `mem_valid` follows `dev_valid`, `mem_addr`/`mem_data` equal the device values, and `dev_ready` equals `mem_ready`. A beat commits in a cycle where `dev_valid` and `mem_ready` are both 1.
- R2: In a hinted transfer, a beat whose zero-based index within the transfer is below `HDR_BYTES/(DW/8)` (rounded up) drives `bus_valid` and `bus_inject` to 1 in its commit cycle. `bus_addr`/`bus_data` carry the beat, provided `bus_busy` is 0.
- R3: Beats at or beyond that header index never appear on the processor bus.
- R4: Beats of a transfer whose hint is 0 never appear on the processor bus.
- R5: The hint is sampled only on beat 0 of a transfer and applies to the whole transfer; `dev_hint` on later beats is ignored. The beat index restarts at 0 after a beat with `dev_last`=1 commits.
- R6: While `bus_busy` is 1, the injection copy is dropped: `bus_valid` stays 0, and `dev_ready` still follows `mem_ready`. No copy is ever issued outside a commit cycle.
- R7: When a marked bus beat arrives while the stub is ready (`fill_valid`=0 or `cache_ready`=1) and `cache_allow`=1, `fill_valid` is 1 in the next cycle with that beat's address and data. The fill is held stable until a cycle with `cache_ready`=1, after which `fill_valid` drops unless a new beat is installed.
- R8: The stub ignores a marked beat without any other effect when `cache_allow`=0, or when it is not ready (`fill_valid`=1 and `cache_ready`=0). In that case any pending fill keeps its old contents.
- R9: `done_irq` goes to 1 in the cycle after the commit of a beat with `dev_last`=1, and never rises at any other time.
- R10: `done_irq` holds until a cycle with `done_ack`=1, and is 0 in the following cycle. A completion in the same cycle as an acknowledge keeps it at 1.
- R11: After reset, `done_irq`, `fill_valid` and `bus_valid` are 0, and the first beat is treated as beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_valid | input | 1 | Device write beat present |
| dev_ready | output | 1 | Beat accepted (follows memory ready) |
| dev_addr | input | AW | Beat address |
| dev_data | input | DW | Beat data |
| dev_last | input | 1 | Final beat of the transfer |
| dev_hint | input | 1 | Injection hint, sampled on beat 0 |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| bus_busy | input | 1 | Processor bus occupied by other traffic |
| bus_valid | output | 1 | Injection copy on the processor bus |
| bus_inject | output | 1 | Injection marker on the bus |
| bus_addr | output | AW | Bus copy address |
| bus_data | output | DW | Bus copy data |
| cache_allow | input | 1 | Stub policy: install marked beats |
| cache_ready | input | 1 | Cache fill port takes the pending fill |
| fill_valid | output | 1 | Pending cache fill |
| fill_addr | output | AW | Fill address |
| fill_data | output | DW | Fill data |
| done_irq | output | 1 | Transfer completion interrupt |
| done_ack | input | 1 | Interrupt acknowledge |

## Verification
Some properties are checked by the assertions on every cycle. A bus copy is only ever issued in a memory commit cycle and inside the header window. The beat index stays bounded and restarts after the last beat. A pending fill stays stable while the cache port stalls, and the interrupt rises only after a final commit and holds until acknowledged. The bench scenarios cover what the assertions cannot. They sweep transfer lengths on both sides of the header window, both hint values, and a hint that flips on later beats. They also cover a busy bus, memory stalls, a stalled or refusing stub, and an acknowledge that lands on a completion, and compare every output cycle by cycle with an independently computed model.

// File: rtl/dmi_pkg.sv
package dmi_pkg;
  function automatic int hdr_beat_count(input int data_w, input int hdr_bytes);
    int bpb;
    bpb = data_w / 8;
    return (hdr_bytes + bpb - 1) / bpb;
  endfunction

  function automatic int ctr_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/dmi_beat_track.sv
module dmi_beat_track #(
  parameter int HB = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic last,
  input  logic hint_in,
  output logic in_window,
  output logic hint_eff
);
  localparam int CW = dmi_pkg::ctr_width(HB);
  localparam logic [CW-1:0] HB_C = CW'(HB);

  logic [CW-1:0] idx_q;
  logic          hint_q;
  logic          first_beat;

  assign first_beat = (idx_q == '0);
  assign in_window  = (idx_q < HB_C);
  assign hint_eff   = first_beat ? hint_in : hint_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      hint_q <= 1'b0;
    end else if (commit) begin
      if (first_beat) hint_q <= hint_in;
      if (last)              idx_q <= '0;
      else if (idx_q != HB_C) idx_q <= idx_q + 1'b1;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= HB_C); // R3
  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    commit && last |=> idx_q == '0); // R5
  AST_HINT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !first_beat |=> $stable(hint_q)); // R5
endmodule

// File: rtl/dmi_snoop_stub.sv
module dmi_snoop_stub #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic          snp_mark,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  input  logic          allow,
  input  logic          cache_ready,
  output logic          stub_ready,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  output logic [DW-1:0] fill_data
);
  logic install;

  assign stub_ready = !fill_valid || cache_ready;
  assign install    = snp_valid && snp_mark && allow && stub_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_data  <= '0;
    end else if (install) begin
      fill_valid <= 1'b1;
      fill_addr  <= snp_addr;
      fill_data  <= snp_data;
    end else if (cache_ready) begin
      fill_valid <= 1'b0;
    end
  end

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !cache_ready |=> fill_valid && $stable(fill_addr) && $stable(fill_data)); // R7
  AST_FILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_mark && allow && !fill_valid |=> fill_valid && fill_addr == $past(snp_addr)); // R7
  AST_IGNORE_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid && !allow |=> !fill_valid); // R8
endmodule

// File: rtl/dmi_done_irq.sv
module dmi_done_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (done_evt) irq <= 1'b1;
    else if (ack)      irq <= 1'b0;
  end

  AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq); // R9
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !done_evt |=> !irq); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq); // R10
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !done_evt |=> !irq); // R10
endmodule

// File: rtl/dma_inject_fwd.sv
module dma_inject_fwd #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int HDR_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_valid,
  output logic          dev_ready,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] dev_data,
  input  logic          dev_last,
  input  logic          dev_hint,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          bus_busy,
  output logic          bus_valid,
  output logic          bus_inject,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          cache_allow,
  input  logic          cache_ready,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  output logic [DW-1:0] fill_data,
  output logic          done_irq,
  input  logic          done_ack
);
  localparam int HB = dmi_pkg::hdr_beat_count(DW, HDR_BYTES);

  logic commit;
  logic final_commit;
  logic in_window;
  logic hint_eff;
  logic copy_cand;
  logic stub_ready;

  // memory path: always written, never stalled by the injection side
  assign mem_valid    = dev_valid;
  assign mem_addr     = dev_addr;
  assign mem_data     = dev_data;
  assign dev_ready    = mem_ready;
  assign commit       = dev_valid && mem_ready;
  assign final_commit = commit && dev_last;

  dmi_beat_track #(.HB(HB)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .last      (dev_last),
    .hint_in   (dev_hint),
    .in_window (in_window),
    .hint_eff  (hint_eff)
  );

  // injection copy: header beats of hinted transfers, dropped when the bus is busy
  assign copy_cand  = commit && hint_eff && in_window;
  assign bus_valid  = copy_cand && !bus_busy;
  assign bus_inject = bus_valid;
  assign bus_addr   = dev_addr;
  assign bus_data   = dev_data;

  dmi_snoop_stub #(.AW(AW), .DW(DW)) u_stub (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid   (bus_valid),
    .snp_mark    (bus_inject),
    .snp_addr    (bus_addr),
    .snp_data    (bus_data),
    .allow       (cache_allow),
    .cache_ready (cache_ready),
    .stub_ready  (stub_ready),
    .fill_valid  (fill_valid),
    .fill_addr   (fill_addr),
    .fill_data   (fill_data)
  );

  dmi_done_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_evt (final_commit),
    .ack      (done_ack),
    .irq      (done_irq)
  );

  AST_COPY_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> mem_valid && mem_ready); // R6
  AST_COPY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> in_window && hint_eff); // R3
  AST_COPY_MATCHES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_addr == mem_addr && bus_data == mem_data); // R2
  AST_DROP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !stub_ready |=> $stable(fill_addr)); // R8
endmodule

// File: tb/dma_inject_fwd_test.sv
module dma_inject_fwd_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int HDR_BYTES = 16;
  localparam int HB = (HDR_BYTES + DW/8 - 1) / (DW/8);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_valid = 0, dev_last = 0, dev_hint = 0;
  logic [AW-1:0] dev_addr = '0;
  logic [DW-1:0] dev_data = '0;
  logic mem_ready = 0, bus_busy = 0, cache_allow = 0, cache_ready = 1, done_ack = 0;
  logic dev_ready, mem_valid, bus_valid, bus_inject, fill_valid, done_irq;
  logic [AW-1:0] mem_addr, bus_addr, fill_addr;
  logic [DW-1:0] mem_data, bus_data, fill_data;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // independent reference state
  int  m_idx = 0;
  bit  m_hint = 0;
  bit  m_fv = 0;
  logic [AW-1:0] m_fa = '0;
  logic [DW-1:0] m_fd = '0;
  bit  m_irq = 0;
  bit  m_prev_done = 0;

  always #5 clk = ~clk;

  dma_inject_fwd #(.AW(AW), .DW(DW), .HDR_BYTES(HDR_BYTES)) uut (
    .clk(clk), .rst_n(rst_n),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_addr(dev_addr),
    .dev_data(dev_data), .dev_last(dev_last), .dev_hint(dev_hint),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .bus_busy(bus_busy), .bus_valid(bus_valid), .bus_inject(bus_inject),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .cache_allow(cache_allow), .cache_ready(cache_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .done_irq(done_irq), .done_ack(done_ack)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs are set at a negedge; check, take the edge, advance the model
  task automatic step();
    bit hs, heff, exp_bus, sready, inst;
    string btag;
    #1;
    hs   = dev_valid && mem_ready;
    heff = (m_idx == 0) ? dev_hint : m_hint;
    exp_bus = hs && heff && (m_idx < HB) && !bus_busy;
    chk("R1", {mem_valid, dev_ready}, {dev_valid, mem_ready});
    if (dev_valid) begin
      chk("R1", mem_addr, dev_addr);
      chk("R1", mem_data, dev_data);
    end
    if (bus_busy && hs) btag = "R6";
    else if (!heff) btag = (m_idx > 0) ? "R5" : "R4";
    else if (m_idx >= HB) btag = "R3";
    else btag = "R2";
    chk(btag, {bus_valid, bus_inject}, {exp_bus, exp_bus});
    if (exp_bus) begin
      chk("R2", bus_addr, dev_addr);
      chk("R2", bus_data, dev_data);
    end
    chk(cache_allow ? "R7" : "R8", fill_valid, m_fv);
    if (m_fv) begin
      chk("R8", fill_addr, m_fa);
      chk("R7", fill_data, m_fd);
    end
    chk(m_prev_done ? "R9" : "R10", done_irq, m_irq);
    sready = !m_fv || cache_ready;
    inst = exp_bus && cache_allow && sready;
    @(posedge clk);
    if (inst) begin m_fv = 1; m_fa = dev_addr; m_fd = dev_data; end
    else if (cache_ready) m_fv = 0;
    m_prev_done = hs && dev_last;
    if (hs && dev_last) m_irq = 1;
    else if (done_ack) m_irq = 0;
    if (hs) begin
      if (m_idx == 0) m_hint = dev_hint;
      m_idx = dev_last ? 0 : m_idx + 1;
    end
    @(negedge clk);
  endtask

  task automatic run_xfer(input int len, input bit hint, input int variant);
    for (int k = 0; k < len; k++) begin
      dev_valid = 1;
      dev_addr = AW'(16'h1000 + len*256 + variant*64 + k*4);
      dev_data = {8'(len), 8'(hint), 8'(variant), 8'(k)};
      dev_last = (k == len - 1);
      dev_hint = (k == 0) ? hint : ~hint;   // R5: later hint values must not matter
      bus_busy = (variant == 1) && (k % 2 == 1);
      cache_ready = (variant != 2);
      cache_allow = (variant != 3);
      done_ack = (variant == 2) && (k == len - 1);   // R10: set wins over ack
      if (variant == 1) begin
        mem_ready = 0;
        step();                                       // stalled beat: no commit, no copy
      end
      mem_ready = 1;
      step();
    end
    dev_valid = 0; dev_last = 0; mem_ready = 0; bus_busy = 0; done_ack = 0;
    step();                                           // R9: irq observed here
    cache_ready = 1;
    done_ack = (variant % 2 == 0);
    step();
    done_ack = 0;
    step();
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11", {done_irq, fill_valid, bus_valid}, 3'b000);
    @(negedge clk);
    for (int len = 1; len <= 7; len++)
      for (int h = 0; h < 2; h++)
        for (int v = 0; v < 4; v++)
          run_xfer(len, h[0], v);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule